// File: doc/BRIEF.md
# PS/2 Keyboard Host Port with Bus Release

This block is the host end of an AT-style PS/2 keyboard link. It works with open-drain clock and data lines. It receives device frames and hands each byte up unchanged. A key press yields one byte and a key release yields two; the port does not interpret them. After a good byte it holds the clock low until the consumer takes the byte, which stops the keyboard from sending more. It can also send one byte to the device. To do that it inhibits the clock, raises a request to send, shifts the bits out on the device's clock and checks the device's acknowledge.

A second controller, such as a menu overlay, may share the same two wires. While the `intercept` input is high, both of the port's drive outputs are released, so the other controller owns the bus. The port still watches the lines and can still receive frames. A transmit that is running when intercept rises is abandoned and reported as failed. A watchdog guards the send path: if the device never starts clocking, or stops part way through a frame, the port releases the lines and reports a timeout. This way an absent keyboard cannot leave the bus held low.

All timing limits are counted in system clock cycles and set by parameters. The defaults suit a 50 MHz clock: 100 us of inhibit, 15 ms to the first device edge, and 2 ms for the rest of the frame.

Top module: `ps2h_port`

## Requirements
- R1: A device frame has 11 bits, each sampled on a falling line clock: a start bit of 0, eight data bits LSB first, a parity bit, then a stop bit of 1. A good frame places its data byte unchanged on `rx_data`, and `rx_valid` goes high.
- R2: Parity is odd: the eight data bits plus the parity bit hold an odd number of ones. A frame whose parity is wrong or whose stop bit is 0 is dropped. `rx_valid` stays low and `rx_err` pulses high for one cycle.
- R3: Once `rx_valid` is high, it and `rx_data` hold until `rx_ack` is high for a cycle. During that time the port pulls the clock line low (`kb_clk_oe`=1). After the byte is taken it releases the clock.
- R4: While `intercept` is high, `kb_clk_oe` and `kb_dat_oe` are both 0, whatever the internal state. The line inputs are still observed, so a frame that arrives during intercept is delivered.
- R5: A `tx_start` pulse while idle first drives the clock low with data released for INHIBIT_CYC cycles. The port then drives data low and releases the clock.
- R6: On falling device clocks 1 to 10 the port presents the data byte LSB first, then odd parity, then a released stop bit. On falling clock 11 it samples data. If data is 0 (acknowledge), `tx_done` pulses for one cycle.
- R7: If data is high at the 11th falling clock, `tx_fail` pulses and `tx_timeout` stays low.
- R8: If no falling device clock comes within REQ_TMO_CYC cycles of the request, the port releases both lines and returns to idle. It pulses `tx_fail` and `tx_timeout` together.
- R9: If the frame has not reached its 11th falling clock within FRAME_TMO_CYC cycles of the first one, the port releases both lines and returns to idle. It pulses `tx_fail` and `tx_timeout` together.
- R10: If `intercept` rises during a transmit, the transmit is abandoned: `tx_busy` drops and `tx_fail` pulses without `tx_timeout`. A `tx_start` while `intercept` is high gives only a `tx_fail` pulse.
- R11: After reset both drive outputs are 0, and `rx_valid`, `tx_busy` and all pulse outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| kb_clk_i | input | 1 | Sensed level of the shared clock line |
| kb_dat_i | input | 1 | Sensed level of the shared data line |
| kb_clk_oe | output | 1 | 1 pulls the clock line low, 0 releases it |
| kb_dat_oe | output | 1 | 1 pulls the data line low, 0 releases it |
| intercept | input | 1 | Releases both line drives so another controller owns the bus |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | A received byte is waiting |
| rx_ack | input | 1 | Consumer takes the waiting byte |
| rx_err | output | 1 | One-cycle pulse on a parity or stop-bit error |
| tx_data | input | 8 | Byte to send |
| tx_start | input | 1 | Begin sending `tx_data` |
| tx_busy | output | 1 | A send is in progress |
| tx_done | output | 1 | One-cycle pulse: the device acknowledged |
| tx_fail | output | 1 | One-cycle pulse: the send did not complete |
| tx_timeout | output | 1 | One-cycle pulse: the failure was caused by the watchdog |

## Verification
Receive is driven with a behavioural keyboard. It sends the all-zero and all-one bytes, a two-byte release sequence, and random bytes in which parity or the stop bit is sometimes corrupted. These patterns separate bit order, the parity sense and the stop check. Send is tried with random bytes against a device that records each released or driven bit. That device can also withhold the acknowledge, never clock at all, or stop after three edges. Each of these ends in a different combination of done, fail and timeout. Intercept is raised during the inhibit phase, before a start, and while a frame arrives, to show that it releases the drives without blinding the receiver.

// File: rtl/ps2h_pkg.sv
package ps2h_pkg;
    typedef enum logic [1:0] {
        TX_IDLE    = 2'd0,
        TX_INHIBIT = 2'd1,
        TX_REQ     = 2'd2,
        TX_SHIFT   = 2'd3
    } tx_state_e;

    localparam int FRAME_BITS = 11;
endpackage

// File: rtl/ps2h_sync.sv
module ps2h_sync #(
    parameter int LINES  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] din,
    output logic [LINES-1:0] dout
);
    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] sh_d, sh_q;
        always_comb begin
            sh_d = {sh_q[STAGES-2:0], din[g]};
        end
        always_ff @(posedge clk) begin
            if (!rst_n) sh_q <= '1;
            else        sh_q <= sh_d;
        end
        assign dout[g] = sh_q[STAGES-1];
    end
endmodule

// File: rtl/ps2h_rx.sv
module ps2h_rx
    import ps2h_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       fall,
    input  logic       dat,
    input  logic       ack,
    output logic [7:0] data,
    output logic       valid,
    output logic       err
);
    localparam int CW = $clog2(FRAME_BITS + 1);

    typedef struct packed {
        logic [FRAME_BITS-1:0] sh;
        logic [CW-1:0]         cnt;
        logic [7:0]            data;
        logic                  valid;
        logic                  err;
    } rx_s;

    rx_s rx_d, rx_q;

    always_comb begin
        logic [FRAME_BITS-1:0] frame;
        rx_d     = rx_q;
        rx_d.err = 1'b0;
        frame    = {dat, rx_q.sh[FRAME_BITS-1:1]};
        if (ack) rx_d.valid = 1'b0;
        if (clr) begin
            rx_d.cnt = '0;
        end else if (fall) begin
            if (rx_q.cnt == '0 && dat) begin
                rx_d.cnt = '0;              // not a start bit: stay aligned
            end else if (rx_q.cnt == CW'(FRAME_BITS - 1)) begin
                rx_d.cnt = '0;
                rx_d.sh  = frame;
                if ((^frame[9:1]) && frame[10]) begin
                    if (!rx_d.valid) begin
                        rx_d.data  = frame[8:1];
                        rx_d.valid = 1'b1;
                    end
                end else begin
                    rx_d.err = 1'b1;
                end
            end else begin
                rx_d.sh  = frame;
                rx_d.cnt = rx_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rx_q <= '0;
        else        rx_q <= rx_d;
    end

    assign data  = rx_q.data;
    assign valid = rx_q.valid;
    assign err   = rx_q.err;

    // R3
    rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_q.valid && !ack) |=> (rx_q.valid && $stable(rx_q.data)));

    // R2
    rx_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_q.err |-> !$rose(rx_q.valid));
endmodule

// File: rtl/ps2h_tx.sv
module ps2h_tx
    import ps2h_pkg::*;
#(
    parameter int INHIBIT_CYC   = 5000,
    parameter int REQ_TMO_CYC   = 750000,
    parameter int FRAME_TMO_CYC = 100000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] data,
    input  logic       abort,
    input  logic       fall,
    input  logic       dat,
    output logic       busy,
    output logic       drv_clk,
    output logic       drv_dat,
    output logic       done,
    output logic       fail,
    output logic       tmo
);
    localparam int MAXC = (INHIBIT_CYC > REQ_TMO_CYC)
                        ? ((INHIBIT_CYC > FRAME_TMO_CYC) ? INHIBIT_CYC : FRAME_TMO_CYC)
                        : ((REQ_TMO_CYC > FRAME_TMO_CYC) ? REQ_TMO_CYC : FRAME_TMO_CYC);
    localparam int TW = $clog2(MAXC + 1);
    localparam int PAYLOAD = FRAME_BITS - 1;        // data, parity, stop
    localparam int NW = $clog2(FRAME_BITS);

    typedef struct packed {
        tx_state_e          st;
        logic [TW-1:0]      tmr;
        logic [PAYLOAD-1:0] frm;
        logic [NW-1:0]      nbit;
        logic               drv_clk;
        logic               drv_dat;
        logic               done;
        logic               fail;
        logic               tmo;
    } tx_s;

    tx_s tx_d, tx_q;

    always_comb begin
        tx_d      = tx_q;
        tx_d.done = 1'b0;
        tx_d.fail = 1'b0;
        tx_d.tmo  = 1'b0;
        unique case (tx_q.st)
            TX_IDLE: begin
                tx_d.drv_clk = 1'b0;
                tx_d.drv_dat = 1'b0;
                if (start) begin
                    if (abort) begin
                        tx_d.fail = 1'b1;
                    end else begin
                        tx_d.st      = TX_INHIBIT;
                        tx_d.tmr     = '0;
                        tx_d.frm     = {1'b1, ~^data, data};
                        tx_d.nbit    = '0;
                        tx_d.drv_clk = 1'b1;
                    end
                end
            end
            TX_INHIBIT: begin
                tx_d.tmr = tx_q.tmr + 1'b1;
                if (tx_q.tmr == TW'(INHIBIT_CYC - 1)) begin
                    tx_d.st      = TX_REQ;
                    tx_d.tmr     = '0;
                    tx_d.drv_dat = 1'b1;
                    tx_d.drv_clk = 1'b0;
                end
            end
            TX_REQ: begin
                tx_d.tmr = tx_q.tmr + 1'b1;
                if (fall) begin
                    tx_d.st      = TX_SHIFT;
                    tx_d.tmr     = '0;
                    tx_d.nbit    = NW'(1);
                    tx_d.drv_dat = ~tx_q.frm[0];
                end else if (tx_q.tmr == TW'(REQ_TMO_CYC - 1)) begin
                    tx_d.st      = TX_IDLE;
                    tx_d.drv_dat = 1'b0;
                    tx_d.fail    = 1'b1;
                    tx_d.tmo     = 1'b1;
                end
            end
            TX_SHIFT: begin
                tx_d.tmr = tx_q.tmr + 1'b1;
                if (fall) begin
                    if (tx_q.nbit == NW'(PAYLOAD)) begin
                        tx_d.st      = TX_IDLE;
                        tx_d.drv_dat = 1'b0;
                        tx_d.done    = !dat;
                        tx_d.fail    = dat;
                    end else begin
                        tx_d.drv_dat = ~tx_q.frm[tx_q.nbit];
                        tx_d.nbit    = tx_q.nbit + 1'b1;
                    end
                end else if (tx_q.tmr == TW'(FRAME_TMO_CYC - 1)) begin
                    tx_d.st      = TX_IDLE;
                    tx_d.drv_dat = 1'b0;
                    tx_d.fail    = 1'b1;
                    tx_d.tmo     = 1'b1;
                end
            end
            default: tx_d.st = TX_IDLE;
        endcase
        if (abort && tx_q.st != TX_IDLE) begin
            tx_d.st      = TX_IDLE;
            tx_d.drv_clk = 1'b0;
            tx_d.drv_dat = 1'b0;
            tx_d.done    = 1'b0;
            tx_d.fail    = 1'b1;
            tx_d.tmo     = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tx_q <= '0;
        else        tx_q <= tx_d;
    end

    assign busy    = (tx_q.st != TX_IDLE);
    assign drv_clk = tx_q.drv_clk;
    assign drv_dat = tx_q.drv_dat;
    assign done    = tx_q.done;
    assign fail    = tx_q.fail;
    assign tmo     = tx_q.tmo;

    // R10
    tx_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (abort && busy) |=> (!busy && fail && !tmo));

    // R6
    tx_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fail));

    // R8
    tx_tmo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmo |-> (fail && !busy && !drv_clk && !drv_dat));

    // R5
    tx_inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !abort) |=> (drv_clk && !drv_dat));
endmodule

// File: rtl/ps2h_port.sv
module ps2h_port #(
    parameter int INHIBIT_CYC   = 5000,
    parameter int REQ_TMO_CYC   = 750000,
    parameter int FRAME_TMO_CYC = 100000,
    parameter int SYNC_STAGES   = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       kb_clk_i,
    input  logic       kb_dat_i,
    output logic       kb_clk_oe,
    output logic       kb_dat_oe,
    input  logic       intercept,
    output logic [7:0] rx_data,
    output logic       rx_valid,
    input  logic       rx_ack,
    output logic       rx_err,
    input  logic [7:0] tx_data,
    input  logic       tx_start,
    output logic       tx_busy,
    output logic       tx_done,
    output logic       tx_fail,
    output logic       tx_timeout
);
    logic [1:0] line_s;
    logic       clk_prev_d, clk_prev_q;
    logic       clk_fall;
    logic       tx_drv_clk, tx_drv_dat;

    ps2h_sync #(.LINES(2), .STAGES(SYNC_STAGES)) i_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({kb_dat_i, kb_clk_i}),
        .dout (line_s)
    );

    always_comb begin
        clk_prev_d = line_s[0];
    end
    always_ff @(posedge clk) begin
        if (!rst_n) clk_prev_q <= 1'b1;
        else        clk_prev_q <= clk_prev_d;
    end
    assign clk_fall = clk_prev_q & ~line_s[0];

    ps2h_rx i_rx (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (tx_busy),
        .fall (clk_fall),
        .dat  (line_s[1]),
        .ack  (rx_ack),
        .data (rx_data),
        .valid(rx_valid),
        .err  (rx_err)
    );

    ps2h_tx #(
        .INHIBIT_CYC  (INHIBIT_CYC),
        .REQ_TMO_CYC  (REQ_TMO_CYC),
        .FRAME_TMO_CYC(FRAME_TMO_CYC)
    ) i_tx (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (tx_start),
        .data   (tx_data),
        .abort  (intercept),
        .fall   (clk_fall),
        .dat    (line_s[1]),
        .busy   (tx_busy),
        .drv_clk(tx_drv_clk),
        .drv_dat(tx_drv_dat),
        .done   (tx_done),
        .fail   (tx_fail),
        .tmo    (tx_timeout)
    );

    assign kb_clk_oe = ~intercept & (tx_busy ? tx_drv_clk : rx_valid);
    assign kb_dat_oe = ~intercept & tx_drv_dat;
endmodule

// File: tb/test_ps2h_port.sv
module test_ps2h_port;
    localparam int INH  = 100;
    localparam int RQT  = 2000;
    localparam int FRT  = 1500;
    localparam int HALF = 25;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dev_clk = 1'b1, dev_dat = 1'b1;
    logic intercept = 1'b0, rx_ack = 1'b0, tx_start = 1'b0;
    logic [7:0] tx_data = '0;
    logic kb_clk_i, kb_dat_i, kb_clk_oe, kb_dat_oe;
    logic [7:0] rx_data;
    logic rx_valid, rx_err, tx_busy, tx_done, tx_fail, tx_timeout;

    int total = 0, bad = 0;
    int n_err = 0, n_done = 0, n_fail = 0, n_tmo = 0;

    always #10 clk = ~clk;

    assign kb_clk_i = dev_clk & ~kb_clk_oe;
    assign kb_dat_i = dev_dat & ~kb_dat_oe;

    ps2h_port #(.INHIBIT_CYC(INH), .REQ_TMO_CYC(RQT), .FRAME_TMO_CYC(FRT)) i_ps2h_port (
        .clk(clk), .rst_n(rst_n), .kb_clk_i(kb_clk_i), .kb_dat_i(kb_dat_i),
        .kb_clk_oe(kb_clk_oe), .kb_dat_oe(kb_dat_oe), .intercept(intercept),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_ack(rx_ack), .rx_err(rx_err),
        .tx_data(tx_data), .tx_start(tx_start), .tx_busy(tx_busy), .tx_done(tx_done),
        .tx_fail(tx_fail), .tx_timeout(tx_timeout)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_err)     n_err++;
            if (tx_done)    n_done++;
            if (tx_fail)    n_fail++;
            if (tx_timeout) n_tmo++;
        end
    end

    function automatic logic [9:0] exp_frame(input logic [7:0] b);
        return {1'b1, ~^b, b};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic dev_send(input logic [7:0] b, input bit bad_par, input bit bad_stop);
        logic [10:0] f;
        f = {~bad_stop, (~^b) ^ bad_par, b, 1'b0};
        for (int i = 0; i < 11; i++) begin
            dev_dat = f[i];
            cyc(HALF); dev_clk = 1'b0;
            cyc(HALF); dev_clk = 1'b1;
        end
        dev_dat = 1'b1;
        cyc(10);
    endtask

    task automatic dev_recv(output logic [9:0] got, input bit give_ack, input int nedges);
        int w = 0;
        got = '0;
        while (!(kb_clk_i && !kb_dat_i) && w < 5000) begin cyc(1); w++; end
        for (int e = 1; e <= nedges; e++) begin
            if (e == 11 && give_ack) dev_dat = 1'b0;
            cyc(HALF); dev_clk = 1'b0;
            cyc(HALF); dev_clk = 1'b1;
            if (e <= 10) got[e-1] = kb_dat_i;
        end
        dev_dat = 1'b1;
    endtask

    task automatic take_byte();
        rx_ack = 1'b1; cyc(1); rx_ack = 1'b0; cyc(1);
    endtask

    task automatic pulse_start(input logic [7:0] b);
        tx_data = b; tx_start = 1'b1; cyc(1); tx_start = 1'b0;
    endtask

    task automatic rx_good(input logic [7:0] b);
        dev_send(b, 1'b0, 1'b0);
        chk(rx_valid === 1'b1, "R1 valid", rx_valid, 1);
        chk(rx_data === b, "R1 data", rx_data, b);
        chk(kb_clk_oe === 1'b1, "R3 hold-off", kb_clk_oe, 1);
        cyc(20);
        chk(rx_valid === 1'b1 && rx_data === b, "R3 stable", rx_data, b);
        take_byte();
        chk(rx_valid === 1'b0 && kb_clk_oe === 1'b0, "R3 release", {rx_valid, kb_clk_oe}, 0);
    endtask

    task automatic tx_good(input logic [7:0] b);
        logic [9:0] got;
        int d0;
        d0 = n_done;
        pulse_start(b);
        dev_recv(got, 1'b1, 11);
        cyc(10);
        chk(got === exp_frame(b), "R6 bits", got, exp_frame(b));
        chk(n_done == d0 + 1 && !tx_busy, "R6 done", n_done, d0 + 1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [9:0] got;
        int e0, f0, t0;
        void'($urandom(32'h51C0DE));
        cyc(5);
        // R11 reset state
        chk(kb_clk_oe === 0 && kb_dat_oe === 0, "R11 drives", {kb_clk_oe, kb_dat_oe}, 0);
        chk(rx_valid === 0 && tx_busy === 0 && tx_done === 0 && tx_fail === 0 && rx_err === 0,
            "R11 flags", {rx_valid, tx_busy, tx_done, tx_fail, rx_err}, 0);
        rst_n = 1'b1;
        cyc(5);

        // R1 / R3 directed patterns, including a two-byte release
        rx_good(8'h00); rx_good(8'hFF); rx_good(8'hF0); rx_good(8'h1C); rx_good(8'h5A);

        // R2 bad parity and bad stop
        e0 = n_err;
        dev_send(8'h3C, 1'b1, 1'b0);
        chk(n_err == e0 + 1 && rx_valid === 0, "R2 parity", n_err, e0 + 1);
        dev_send(8'hA5, 1'b0, 1'b1);
        chk(n_err == e0 + 2 && rx_valid === 0, "R2 stop", n_err, e0 + 2);

        // R1 / R2 random receive
        for (int i = 0; i < 16; i++) begin
            logic [7:0] b;
            int k;
            b = 8'($urandom);
            k = $urandom % 4;
            if (k == 0) begin
                e0 = n_err;
                dev_send(b, 1'b1, 1'b0);
                chk(n_err == e0 + 1 && rx_valid === 0, "R2 random", n_err, e0 + 1);
            end else begin
                rx_good(b);
            end
        end

        // R5 inhibit then request
        tx_data = 8'hED; tx_start = 1'b1; cyc(1); tx_start = 1'b0;
        cyc(50);
        chk(kb_clk_oe === 1 && kb_dat_oe === 0, "R5 inhibit", {kb_clk_oe, kb_dat_oe}, 2);
        cyc(INH);
        chk(kb_clk_oe === 0 && kb_dat_oe === 1, "R5 request", {kb_clk_oe, kb_dat_oe}, 1);
        dev_recv(got, 1'b1, 11);
        cyc(10);
        chk(got === exp_frame(8'hED), "R6 bits ED", got, exp_frame(8'hED));

        // R6 random transmit
        for (int i = 0; i < 8; i++) tx_good(8'($urandom));
        tx_good(8'h00); tx_good(8'hFF);

        // R7 no acknowledge
        f0 = n_fail; t0 = n_tmo;
        pulse_start(8'hF4);
        dev_recv(got, 1'b0, 11);
        cyc(10);
        chk(n_fail == f0 + 1 && n_tmo == t0, "R7 nack", {n_fail, n_tmo}, {f0 + 1, t0});

        // R8 device never clocks
        f0 = n_fail; t0 = n_tmo;
        pulse_start(8'hFF);
        cyc(INH + RQT + 20);
        chk(n_fail == f0 + 1 && n_tmo == t0 + 1, "R8 timeout", {n_fail, n_tmo}, {f0 + 1, t0 + 1});
        chk(kb_clk_oe === 0 && kb_dat_oe === 0 && !tx_busy, "R8 released", {kb_clk_oe, kb_dat_oe, tx_busy}, 0);

        // R9 device stalls mid-frame
        f0 = n_fail; t0 = n_tmo;
        pulse_start(8'h55);
        dev_recv(got, 1'b0, 3);
        cyc(FRT + 100);
        chk(n_fail == f0 + 1 && n_tmo == t0 + 1, "R9 timeout", {n_fail, n_tmo}, {f0 + 1, t0 + 1});
        chk(kb_clk_oe === 0 && kb_dat_oe === 0 && !tx_busy, "R9 released", {kb_clk_oe, kb_dat_oe, tx_busy}, 0);

        // R10 / R4 intercept during inhibit
        f0 = n_fail; t0 = n_tmo;
        pulse_start(8'hAA);
        cyc(50);
        intercept = 1'b1;
        cyc(1);
        chk(kb_clk_oe === 0 && kb_dat_oe === 0, "R4 masked", {kb_clk_oe, kb_dat_oe}, 0);
        cyc(5);
        chk(!tx_busy && n_fail == f0 + 1 && n_tmo == t0, "R10 abort", {tx_busy, n_fail, n_tmo}, {1'b0, f0 + 1, t0});

        // R10 start while intercepted
        f0 = n_fail;
        pulse_start(8'h11);
        cyc(3);
        chk(!tx_busy && n_fail == f0 + 1, "R10 start blocked", {tx_busy, n_fail}, {1'b0, f0 + 1});

        // R4 receive still works under intercept, hold-off masked
        dev_send(8'h6B, 1'b0, 1'b0);
        chk(rx_valid === 1 && rx_data === 8'h6B, "R4 rx", rx_data, 8'h6B);
        chk(kb_clk_oe === 0, "R4 clk masked", kb_clk_oe, 0);
        intercept = 1'b0;
        cyc(1);
        chk(kb_clk_oe === 1, "R3 hold-off resumes", kb_clk_oe, 1);
        take_byte();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule